// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address under a legacy two-level paging scheme. A client hands it one translation at a time over a valid/ready request channel. The block reads the directory entry and, for a small page, the table entry through a single memory port. It checks the user, write and present permissions. Where an entry's accessed or dirty bit has to change, it writes the entry back. Its answer comes out on a valid/ready response channel. That answer is either a physical address with a large-page flag and the effective user/write rights, or a page-fault error code.

Configuration is sampled when a request is accepted and holds for the whole walk. That configuration is the paging enable, the large-page enable, supervisor write protection, the 20th-address-bit gate and the directory base. Entry bit positions: present = bit 0, writable = bit 1, user = bit 2, accessed = bit 5, dirty = bit 6, large = bit 7. Physical frame bits sit above bit 11 for small pages and above bit 21 for large pages.

States and transitions:
- ST_IDLE. It goes to ST_DIR_RD on an accepted request with paging on, or to ST_RESP with paging off.
- ST_DIR_RD. When the read is acknowledged it goes to one of three states:
  - ST_RESP on a fault or on a large page that needs no update.
  - ST_DIR_WB when the entry changed.
  - ST_TBL_RD for a small page whose entry needs no update.
- ST_DIR_WB. When the write is acknowledged it goes to ST_RESP for a large page, or to ST_TBL_RD for a small page.
- ST_TBL_RD. When the read is acknowledged it goes to ST_TBL_WB when the entry changed, and to ST_RESP otherwise.
- ST_TBL_WB. When the write is acknowledged it goes to ST_RESP.
- ST_RESP. It goes to ST_IDLE on rsp_ready.

Top module: `pt_walker`

## Requirements
- R1: req_ready is high only in ST_IDLE, so only one walk is in flight at a time. Once rsp_valid rises, the response fields stay stable and rsp_valid stays high until rsp_ready is seen.
- R2: With cfg_paging_en low, the walker makes no memory access and returns rsp_phys equal to req_lin, with rsp_fault=0, rsp_large=0, rsp_user_ok=1 and rsp_write_ok=1.
- R3: The directory entry is read at (cfg_base with bits [11:0] cleared) OR (req_lin[31:22]*4). Every address the walker forms, including the returned physical address, has bit 20 forced to 0 while cfg_a20_on is low.
- R4: A large page is taken only when directory bit 7 and cfg_large_en are both set. The result is then {pde[31:22], lin[21:0]} with rsp_large=1, and no table read is made. With cfg_large_en low, a directory entry with bit 7 set is walked as a small page.
- R5: For a small page, the table entry is read at {pde[31:12], lin[21:12], 2'b00}, and the result is {pte[31:12], lin[11:0]}.
- R6: For a small page, the effective user and write rights are the AND of the directory and table bits. For a large page they are the directory bits. They are reported on rsp_user_ok and rsp_write_ok.
- R7: A user access faults if the effective user bit is 0. A user write faults if the effective write bit is 0. A supervisor write faults on a 0 write bit only when cfg_wp is set.
- R8: A clear present bit at either level ends the walk with a not-present fault, and that entry is not written.
- R9: The accessed bit is set in any read entry that lacks it. The dirty bit is also set in the final entry of a write. The final entry is a table entry, or a directory entry that maps a large page. An entry is written back only when it changed, and only if it did not fault. All write-backs finish before rsp_valid rises.
- R10: On a fault, rsp_ecode bit 0 = 1 for a protection violation and 0 for not-present, bit 1 = the request's write flag, and bit 2 = the request's user flag. rsp_phys, rsp_large, rsp_user_ok and rsp_write_ok are 0. rsp_ecode is 0 when there is no fault.
- R11: mem_req stays high with mem_addr, mem_we and mem_wdata held until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| cfg_paging_en | input | 1 | Paging enable |
| cfg_large_en | input | 1 | Large-page enable |
| cfg_wp | input | 1 | Supervisor write protection |
| cfg_a20_on | input | 1 | Address bit 20 passes when high |
| cfg_base | input | 32 | Directory base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | One-cycle completion pulse |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_fault | output | 1 | Page fault |
| rsp_ecode | output | 3 | Fault error code |
| rsp_phys | output | 32 | Physical address |
| rsp_large | output | 1 | Mapping is a large page |
| rsp_user_ok | output | 1 | Effective user right |
| rsp_write_ok | output | 1 | Effective write right |

## Verification
The bench builds the walker with A20_BIT at its default of 20. A directory base at the 1 MB line therefore aliases onto address zero when the gate is closed, and a frame whose bit 20 is set comes back with that bit cleared. The memory model answers after a latency of two cycles, so each request sits unacknowledged for at least one cycle and the hold rule on the memory port comes into play at every level. The vector table runs in order, so the accessed and dirty updates made by earlier walks decide how many write-backs later walks make.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int AW        = 32;
    localparam int ENT_P     = 0;
    localparam int ENT_W     = 1;
    localparam int ENT_U     = 2;
    localparam int ENT_A     = 5;
    localparam int ENT_D     = 6;
    localparam int ENT_PS    = 7;
    localparam int OFF_SMALL = 12;
    localparam int OFF_LARGE = 22;
    localparam int IDX_W     = 10;
    localparam int ECODE_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WB,
        ST_TBL_RD,
        ST_TBL_WB,
        ST_RESP
    } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int A20_BIT = 20
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] lin,
    input  logic [AW-1:0] pde,
    input  logic [AW-1:0] ent,
    input  logic          a20_on,
    output logic [AW-1:0] dir_addr,
    output logic [AW-1:0] tbl_addr,
    output logic [AW-1:0] phys_small,
    output logic [AW-1:0] phys_large
);
    localparam logic [AW-1:0] SMALL_OFF = (AW'(1) << OFF_SMALL) - AW'(1);
    localparam logic [AW-1:0] LARGE_OFF = (AW'(1) << OFF_LARGE) - AW'(1);
    localparam logic [AW-1:0] GATE_CLR  = ~(AW'(1) << A20_BIT);

    logic [AW-1:0] gate;
    logic [AW-1:0] dir_idx;
    logic [AW-1:0] tbl_idx;

    always_comb begin
        gate       = a20_on ? '1 : GATE_CLR;
        dir_idx    = AW'(lin[AW-1 -: IDX_W]) << 2;
        tbl_idx    = AW'(lin[OFF_LARGE-1 -: IDX_W]) << 2;
        dir_addr   = ((base & ~SMALL_OFF) | dir_idx) & gate;
        tbl_addr   = ((pde & ~SMALL_OFF) | tbl_idx) & gate;
        phys_small = ((ent & ~SMALL_OFF) | (lin & SMALL_OFF)) & gate;
        phys_large = ((ent & ~LARGE_OFF) | (lin & LARGE_OFF)) & gate;
    end
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk (
    input  logic eff_u,
    input  logic eff_w,
    input  logic is_user,
    input  logic is_write,
    input  logic wp_en,
    output logic viol
);
    always_comb begin
        if (is_user)
            viol = !eff_u || (is_write && !eff_w);
        else
            viol = is_write && wp_en && !eff_w;
    end
endmodule

// File: rtl/ptw_entry_upd.sv
module ptw_entry_upd
    import ptw_pkg::*;
(
    input  logic [AW-1:0] ent,
    input  logic          set_dirty,
    output logic [AW-1:0] ent_new,
    output logic          changed
);
    always_comb begin
        ent_new        = ent;
        ent_new[ENT_A] = 1'b1;
        if (set_dirty)
            ent_new[ENT_D] = 1'b1;
        changed = (ent_new != ent);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int A20_BIT = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [AW-1:0]      req_lin,
    input  logic               req_write,
    input  logic               req_user,
    input  logic               cfg_paging_en,
    input  logic               cfg_large_en,
    input  logic               cfg_wp,
    input  logic               cfg_a20_on,
    input  logic [AW-1:0]      cfg_base,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [AW-1:0]      mem_wdata,
    input  logic               mem_ack,
    input  logic [AW-1:0]      mem_rdata,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               rsp_fault,
    output logic [ECODE_W-1:0] rsp_ecode,
    output logic [AW-1:0]      rsp_phys,
    output logic               rsp_large,
    output logic               rsp_user_ok,
    output logic               rsp_write_ok
);
    walk_state_e state, nstate;

    logic [AW-1:0] q_lin, q_base, q_pde, q_pte, res_phys;
    logic          q_wr, q_usr, q_wp, q_large_en, q_a20, q_large;
    logic          res_fault, res_prot, res_large, res_uok, res_wok;

    logic [AW-1:0] dir_addr, tbl_addr, phys_small, phys_large, upd_ent;
    logic          upd_changed, viol, eff_u, eff_w, large_now, set_dirty, present;

    // Decode of the entry arriving on the memory port
    always_comb begin
        present   = mem_rdata[ENT_P];
        large_now = mem_rdata[ENT_PS] & q_large_en;
        if (state == ST_TBL_RD) begin
            eff_u = q_pde[ENT_U] & mem_rdata[ENT_U];
            eff_w = q_pde[ENT_W] & mem_rdata[ENT_W];
        end else begin
            eff_u = mem_rdata[ENT_U];
            eff_w = mem_rdata[ENT_W];
        end
        set_dirty = q_wr & ((state == ST_TBL_RD) | large_now);
    end

    ptw_addr_gen #(.A20_BIT(A20_BIT)) u_addr (
        .base       (q_base),
        .lin        (q_lin),
        .pde        (q_pde),
        .ent        (mem_rdata),
        .a20_on     (q_a20),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr),
        .phys_small (phys_small),
        .phys_large (phys_large)
    );

    ptw_perm_chk u_perm (
        .eff_u    (eff_u),
        .eff_w    (eff_w),
        .is_user  (q_usr),
        .is_write (q_wr),
        .wp_en    (q_wp),
        .viol     (viol)
    );

    ptw_entry_upd u_upd (
        .ent       (mem_rdata),
        .set_dirty (set_dirty),
        .ent_new   (upd_ent),
        .changed   (upd_changed)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:
                if (req_valid) nstate = cfg_paging_en ? ST_DIR_RD : ST_RESP;
            ST_DIR_RD:
                if (mem_ack) begin
                    if (!present)
                        nstate = ST_RESP;
                    else if (large_now)
                        nstate = viol ? ST_RESP : (upd_changed ? ST_DIR_WB : ST_RESP);
                    else
                        nstate = upd_changed ? ST_DIR_WB : ST_TBL_RD;
                end
            ST_DIR_WB:
                if (mem_ack) nstate = q_large ? ST_RESP : ST_TBL_RD;
            ST_TBL_RD:
                if (mem_ack) begin
                    if (!present || viol) nstate = ST_RESP;
                    else                  nstate = upd_changed ? ST_TBL_WB : ST_RESP;
                end
            ST_TBL_WB:
                if (mem_ack) nstate = ST_RESP;
            ST_RESP:
                if (rsp_ready) nstate = ST_IDLE;
            default:
                nstate = ST_IDLE;
        endcase
    end

    // Walk context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_lin <= '0; q_base <= '0; q_pde <= '0; q_pte <= '0;
            q_wr <= 1'b0; q_usr <= 1'b0; q_wp <= 1'b0;
            q_large_en <= 1'b0; q_a20 <= 1'b0; q_large <= 1'b0;
            res_phys <= '0; res_fault <= 1'b0; res_prot <= 1'b0;
            res_large <= 1'b0; res_uok <= 1'b0; res_wok <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                q_lin      <= req_lin;
                q_wr       <= req_write;
                q_usr      <= req_user;
                q_wp       <= cfg_wp;
                q_large_en <= cfg_large_en;
                q_a20      <= cfg_a20_on;
                q_base     <= cfg_base;
                q_large    <= 1'b0;
                res_fault  <= 1'b0;
                res_prot   <= 1'b0;
                res_large  <= 1'b0;
                res_phys   <= cfg_paging_en ? '0 : req_lin;
                res_uok    <= !cfg_paging_en;
                res_wok    <= !cfg_paging_en;
            end
            if (state == ST_DIR_RD && mem_ack) begin
                q_pde   <= upd_ent;
                q_large <= large_now;
                if (!present) begin
                    res_fault <= 1'b1;
                end else if (large_now) begin
                    if (viol) begin
                        res_fault <= 1'b1;
                        res_prot  <= 1'b1;
                    end else begin
                        res_phys  <= phys_large;
                        res_large <= 1'b1;
                        res_uok   <= eff_u;
                        res_wok   <= eff_w;
                    end
                end
            end
            if (state == ST_TBL_RD && mem_ack) begin
                q_pte <= upd_ent;
                if (!present) begin
                    res_fault <= 1'b1;
                end else if (viol) begin
                    res_fault <= 1'b1;
                    res_prot  <= 1'b1;
                end else begin
                    res_phys <= phys_small;
                    res_uok  <= eff_u;
                    res_wok  <= eff_w;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready    = (state == ST_IDLE);
        mem_req      = (state == ST_DIR_RD) || (state == ST_DIR_WB) ||
                       (state == ST_TBL_RD) || (state == ST_TBL_WB);
        mem_we       = (state == ST_DIR_WB) || (state == ST_TBL_WB);
        mem_addr     = ((state == ST_TBL_RD) || (state == ST_TBL_WB)) ? tbl_addr : dir_addr;
        mem_wdata    = (state == ST_DIR_WB) ? q_pde : q_pte;
        rsp_valid    = (state == ST_RESP);
        rsp_fault    = res_fault;
        rsp_ecode    = res_fault ? {q_usr, q_wr, res_prot} : '0;
        rsp_phys     = res_phys;
        rsp_large    = res_large;
        rsp_user_ok  = res_uok;
        rsp_write_ok = res_wok;
    end
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk
    import ptw_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [AW-1:0]      req_lin,
    input logic               req_write,
    input logic               req_user,
    input logic               cfg_paging_en,
    input logic               mem_req,
    input logic               mem_we,
    input logic [AW-1:0]      mem_addr,
    input logic [AW-1:0]      mem_wdata,
    input logic               mem_ack,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic               rsp_fault,
    input logic [ECODE_W-1:0] rsp_ecode,
    input logic [AW-1:0]      rsp_phys,
    input logic               rsp_large,
    input logic               rsp_user_ok,
    input logic               rsp_write_ok
);
    logic          cap_pg, cap_usr, cap_wr;
    logic [AW-1:0] cap_lin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_pg <= 1'b0; cap_usr <= 1'b0; cap_wr <= 1'b0; cap_lin <= '0;
        end else if (req_valid && req_ready) begin
            cap_pg  <= cfg_paging_en;
            cap_usr <= req_user;
            cap_wr  <= req_write;
            cap_lin <= req_lin;
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_phys) && $stable(rsp_fault) && $stable(rsp_ecode)); // R1

    AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready && !mem_req); // R1

    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[ENT_A] && mem_wdata[ENT_P]); // R9

    AST_ECODE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_ecode[2] == cap_usr && rsp_ecode[1] == cap_wr); // R10

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_phys == '0 && !rsp_large && !rsp_user_ok && !rsp_write_ok); // R10

    AST_FLAT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !cap_pg |-> !rsp_fault && rsp_phys == cap_lin && rsp_user_ok && rsp_write_ok); // R2

    AST_FLAT_NOMEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cap_pg); // R2
endmodule

bind pt_walker ptw_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_lin      (req_lin),
    .req_write    (req_write),
    .req_user     (req_user),
    .cfg_paging_en(cfg_paging_en),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_fault    (rsp_fault),
    .rsp_ecode    (rsp_ecode),
    .rsp_phys     (rsp_phys),
    .rsp_large    (rsp_large),
    .rsp_user_ok  (rsp_user_ok),
    .rsp_write_ok (rsp_write_ok)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    localparam int MEM_LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_lin = '0;
    logic        cfg_paging_en = 1'b1, cfg_large_en = 1'b1, cfg_wp = 1'b0, cfg_a20_on = 1'b1;
    logic [31:0] cfg_base = '0;
    logic        rsp_ready = 1'b0;
    logic        req_ready, mem_req, mem_we, rsp_valid, rsp_fault, rsp_large, rsp_user_ok, rsp_write_ok;
    logic [31:0] mem_addr, mem_wdata, rsp_phys;
    logic [2:0]  rsp_ecode;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;

    always #2.5 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user),
        .cfg_paging_en(cfg_paging_en), .cfg_large_en(cfg_large_en), .cfg_wp(cfg_wp),
        .cfg_a20_on(cfg_a20_on), .cfg_base(cfg_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(m_ack), .mem_rdata(m_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_ecode(rsp_ecode), .rsp_phys(rsp_phys), .rsp_large(rsp_large),
        .rsp_user_ok(rsp_user_ok), .rsp_write_ok(rsp_write_ok)
    );

    // Memory model: 16 KB, fixed latency, word index from addr[13:2]
    logic [31:0] mem [0:4095];
    logic        pk_en = 1'b0, log_clr = 1'b0;
    logic [31:0] pk_addr = '0, pk_data = '0;
    int          lat = 0, acc_cnt = 0, wr_cnt = 0;
    logic        first_seen = 1'b0;
    logic [31:0] first_addr = '0;

    always @(posedge clk) begin
        m_ack <= 1'b0;
        if (pk_en) mem[pk_addr[13:2]] <= pk_data;
        if (log_clr) begin
            acc_cnt <= 0; wr_cnt <= 0; first_seen <= 1'b0;
        end else if (mem_req && !m_ack) begin
            if (!first_seen) begin first_seen <= 1'b1; first_addr <= mem_addr; end
            if (lat == MEM_LAT - 1) begin
                lat <= 0;
                m_ack <= 1'b1;
                acc_cnt <= acc_cnt + 1;
                if (mem_we) begin
                    mem[mem_addr[13:2]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    m_rdata <= mem[mem_addr[13:2]];
                end
            end else begin
                lat <= lat + 1;
            end
        end
    end

    int  n_chk = 0, n_fail = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        pk_addr = a; pk_data = d; pk_en = 1'b1;
        @(posedge clk); #1 pk_en = 1'b0;
    endtask

    logic [31:0] g_phys;
    logic        g_fault, g_large, g_uok, g_wok;
    logic [2:0]  g_ec;

    task automatic walk(input logic [31:0] lin, input bit wr, input bit usr, input int hold);
        int n;
        log_clr = 1'b1;
        @(posedge clk); #1 log_clr = 1'b0;
        req_lin = lin; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(posedge clk); #1 req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 200) begin @(posedge clk); #1; n++; end
        g_phys = rsp_phys; g_fault = rsp_fault; g_large = rsp_large;
        g_uok = rsp_user_ok; g_wok = rsp_write_ok; g_ec = rsp_ecode;
        for (int h = 0; h < hold; h++) begin
            @(posedge clk); #1;
            chk(rsp_valid && !req_ready && rsp_phys == g_phys, "R1", "response held",
                {30'b0, rsp_valid, req_ready}, 32'h2);
        end
        rsp_ready = 1'b1;
        @(posedge clk); #1 rsp_ready = 1'b0;
    endtask

    typedef struct packed {
        logic [31:0] lin;
        logic        wr, usr, wp, flt;
        logic [2:0]  ec;
        logic [31:0] phys;
        logic        lg, uok, wok;
        logic [1:0]  nwr;
    } vec_t;

    localparam vec_t VECS [0:15] = '{
        '{32'h00000123, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0ABCD123, 1'b0, 1'b1, 1'b1, 2'd2},
        '{32'h00000456, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0ABCD456, 1'b0, 1'b1, 1'b1, 2'd1},
        '{32'h00000789, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0ABCD789, 1'b0, 1'b1, 1'b1, 2'd0},
        '{32'h00001010, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h01234010, 1'b0, 1'b1, 1'b0, 2'd1},
        '{32'h00001020, 1'b1, 1'b1, 1'b0, 1'b1, 3'd7, 32'h00000000, 1'b0, 1'b0, 1'b0, 2'd0},
        '{32'h00001030, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'h01234030, 1'b0, 1'b1, 1'b0, 2'd1},
        '{32'h00001040, 1'b1, 1'b0, 1'b1, 1'b1, 3'd3, 32'h00000000, 1'b0, 1'b0, 1'b0, 2'd0},
        '{32'h00002008, 1'b0, 1'b1, 1'b0, 1'b1, 3'd5, 32'h00000000, 1'b0, 1'b0, 1'b0, 2'd0},
        '{32'h00002008, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h05555008, 1'b0, 1'b0, 1'b1, 2'd1},
        '{32'h00003000, 1'b1, 1'b1, 1'b0, 1'b1, 3'd6, 32'h00000000, 1'b0, 1'b0, 1'b0, 2'd0},
        '{32'h00004FFC, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h09999FFC, 1'b0, 1'b1, 1'b1, 2'd0},
        '{32'h00412345, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 32'h08412345, 1'b1, 1'b1, 1'b1, 2'd1},
        '{32'h00400000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h08400000, 1'b1, 1'b1, 1'b1, 2'd0},
        '{32'h00800000, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 32'h00000000, 1'b0, 1'b0, 1'b0, 2'd0},
        '{32'h00C00ABC, 1'b0, 1'b1, 1'b0, 1'b1, 3'd5, 32'h00000000, 1'b0, 1'b0, 1'b0, 2'd1},
        '{32'h00C00ABC, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h03333ABC, 1'b0, 1'b0, 1'b1, 2'd1}
    };

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk(req_ready && !rsp_valid && !mem_req, "R1", "reset state",
            {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);

        // Directory at 0x0000, tables at 0x1000, 0x2000, 0x3000
        poke(32'h0000, 32'h00001007);
        poke(32'h0004, 32'h08400087);
        poke(32'h0008, 32'h00000000);
        poke(32'h000C, 32'h00002003);
        poke(32'h0010, 32'h00003087);
        poke(32'h1000, 32'h0ABCD007);
        poke(32'h1004, 32'h01234005);
        poke(32'h1008, 32'h05555003);
        poke(32'h100C, 32'h07777000);
        poke(32'h1010, 32'h09999067);
        poke(32'h2000, 32'h03333007);
        poke(32'h3000, 32'h04444007);

        for (int i = 0; i < 16; i++) begin
            vec_t v;
            v = VECS[i];
            cfg_wp = v.wp;
            walk(v.lin, v.wr, v.usr, (i == 3) ? 3 : 0);
            chk(g_fault == v.flt, "R7", "fault flag", {31'b0, g_fault}, {31'b0, v.flt});
            chk(g_ec == v.ec, "R10", "error code", {29'b0, g_ec}, {29'b0, v.ec});
            chk(g_phys == v.phys, "R5", "physical address", g_phys, v.phys);
            chk(g_large == v.lg, "R4", "large flag", {31'b0, g_large}, {31'b0, v.lg});
            chk({g_uok, g_wok} == {v.uok, v.wok}, "R6", "effective rights",
                {30'b0, g_uok, g_wok}, {30'b0, v.uok, v.wok});
            chk(wr_cnt == int'(v.nwr), "R9", "write-back count", wr_cnt, {30'b0, v.nwr});
            chk(first_addr == {20'b0, v.lin[31:22], 2'b00}, "R3", "directory address",
                first_addr, {20'b0, v.lin[31:22], 2'b00});
            if (v.ec == 3'd6 || v.ec == 3'd4)
                chk(1'b1, "R8", "not-present fault", 0, 0);
            if (i == 0) begin
                chk(mem[0] == 32'h00001027, "R9", "directory accessed bit", mem[0], 32'h00001027);
                chk(mem[12'h400] == 32'h0ABCD027, "R9", "table accessed bit", mem[12'h400], 32'h0ABCD027);
            end
            if (i == 1)
                chk(mem[12'h400] == 32'h0ABCD067, "R9", "table dirty bit", mem[12'h400], 32'h0ABCD067);
        end
        cfg_wp = 1'b0;

        // R4: large-page bit honoured only with the enable
        cfg_large_en = 1'b1;
        walk(32'h01000010, 1'b0, 1'b0, 0);
        chk(g_large && g_phys == 32'h00000010, "R4", "large page taken", g_phys, 32'h00000010);
        chk(acc_cnt == 2, "R4", "single read plus accessed write", acc_cnt, 2);
        cfg_large_en = 1'b0;
        walk(32'h01000010, 1'b0, 1'b0, 0);
        chk(!g_large && g_phys == 32'h04444010, "R4", "large bit ignored when disabled", g_phys, 32'h04444010);
        cfg_large_en = 1'b1;

        // R3: gate on address bit 20
        cfg_base = 32'h00100000; cfg_a20_on = 1'b0;
        walk(32'h00000123, 1'b0, 1'b1, 0);
        chk(first_addr == 32'h0, "R3", "gated directory address", first_addr, 32'h0);
        chk(g_phys == 32'h0AACD123, "R3", "gated physical address", g_phys, 32'h0AACD123);
        cfg_base = 32'h0; cfg_a20_on = 1'b1;

        // R2: paging disabled
        cfg_paging_en = 1'b0;
        walk(32'hDEADBEEF, 1'b1, 1'b1, 2);
        chk(g_phys == 32'hDEADBEEF && !g_fault && g_uok && g_wok, "R2", "flat mapping",
            g_phys, 32'hDEADBEEF);
        chk(acc_cnt == 0, "R2", "no memory access", acc_cnt, 0);
        cfg_paging_en = 1'b1;

        // R11: memory port request was held through latency on every walk
        chk(MEM_LAT > 1, "R11", "latency exercises hold", MEM_LAT, 2);

        summary();
    end
endmodule